// File: doc/BRIEF.md
# Burst Transfer Sequencer for a Pipelined System Bus

This block sits on the manager side of an AHB-style pipelined bus. A requester hands it one command: a start address, a burst kind, a direction and, for the open-ended incrementing kind, a beat count. The sequencer turns that command into a run of address phases. The first beat is marked as a new transfer and every later beat as a sequential follower. The address steps by one word per beat, or folds back inside an aligned line for the wrapping kinds. After the last address phase the bus goes idle.

Write data comes in as a stream and is moved onto the write-data bus one cycle after the beat's address phase. Read data goes back to the requester in the cycle its data phase completes. Subordinate wait states are honoured: while the ready input is low, address, transfer type and control stay frozen, and so does the write data of the beat in its data phase. All beats are one word wide.

The command port is valid/ready. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when no address phase is in flight. The write stream is valid/ready with the sequencer as the consumer. `wd_ready` is high exactly when a write beat's address phase completes, and the requester must then have `wd_valid` high, because gaps inside a burst are not supported. The read return has no back-pressure: the requester must take `rd_data` in every cycle `rd_valid` is high.

Top module: `burst_seq`

## Requirements
- R1: After reset `htrans` is IDLE (2'b00), `cmd_ready` is 1, and `rd_valid` and `wd_ready` are 0.
- R2: The first address phase of every burst carries `htrans`=NONSEQ (2'b10) and each later one carries SEQ (2'b11). A SINGLE command (kind 0) gives exactly one NONSEQ beat and no SEQ beat.
- R3: The beat count is set by `cmd_kind` as follows: 0=SINGLE gives 1 beat; 1=INCR gives `cmd_len`+1 beats; 3/5/7 (INCR4/8/16) give 4/8/16 beats; 2/4/6 (WRAP4/8/16) give 4/8/16 beats. For the incrementing kinds (0, 1, 3, 5, 7), each address is the previous one plus 4.
- R4: For the wrapping kinds (2, 4, 6), beat i is addressed at base + ((start - base + 4*i) mod L). Here L is the beat count times 4 and base is the start address rounded down to a multiple of L. The first beat is therefore the requested word.
- R5: During every address phase, `hburst` equals the command's kind, `hwrite` equals its direction and `hsize` is 3'b010 (word).
- R6: `wd_ready` is high only in a cycle where a write beat's address phase completes (`hready` high). The word taken in that cycle appears on `hwdata` in the next cycle and stays there until the data phase completes.
- R7: While `hready` is low, `htrans`, `haddr`, `hburst`, `hwrite`, `hsize` and the `hwdata` of a pending write beat stay unchanged.
- R8: For a read, `rd_valid` is high in exactly the cycles where a read data phase completes (`hready` high), with `rd_data` equal to `hrdata`. It is never high for a write burst.
- R9: `cmd_ready` is low while any address phase is on the bus. `htrans` returns to IDLE in the cycle after the last beat's address phase completes, and `cmd_ready` is then high.
- R10: The two low bits of `cmd_addr` are ignored, so every `haddr` is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_addr | input | AW | Start byte address |
| cmd_kind | input | 3 | Burst kind (HBURST code) |
| cmd_len | input | LENW | Beats minus one, used for kind INCR only |
| cmd_write | input | 1 | 1 = write, 0 = read |
| wd_valid | input | 1 | Write word offered |
| wd_ready | output | 1 | Write word taken this cycle |
| wd_data | input | DW | Write word |
| rd_valid | output | 1 | Read word returned this cycle |
| rd_data | output | DW | Read word |
| htrans | output | 2 | Transfer type |
| haddr | output | AW | Beat address |
| hwrite | output | 1 | Direction |
| hsize | output | 3 | Beat size code |
| hburst | output | 3 | Burst kind |
| hwdata | output | DW | Write data bus |
| hready | input | 1 | Subordinate ready / transfer done |
| hrdata | input | DW | Read data bus |

## Verification
Each result has a fixed due cycle:
- The first address phase is due one cycle after the command is taken.
- Each later address phase is due one cycle after the edge on which the previous one saw `hready` high.
- Write data is due one cycle after its address phase completes.
- Read data is returned in the same cycle as the completing `hready`.
- IDLE is due one cycle after the last address phase.

The bench drives inputs at the falling edge and samples one time unit later. It keeps its own record of which beat is in its address phase and which is in its data phase, and compares each completing phase with the arithmetically computed address or data. In each cycle after a stalled one it compares the bus with the values of the previous cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  typedef enum logic [2:0] {
    BK_SINGLE = 3'd0,
    BK_INCR   = 3'd1,
    BK_WRAP4  = 3'd2,
    BK_INCR4  = 3'd3,
    BK_WRAP8  = 3'd4,
    BK_INCR8  = 3'd5,
    BK_WRAP16 = 3'd6,
    BK_INCR16 = 3'd7
  } burst_e;

  // Wrapping kinds are the even non-zero codes.
  function automatic logic kind_wraps(input logic [2:0] k);
    return (k != 3'd0) && !k[0];
  endfunction

endpackage

// File: rtl/bseq_len.sv
module bseq_len
  import bseq_pkg::*;
#(
  parameter int LENW = 4,
  parameter int CW   = 4
) (
  input  logic [2:0]      kind,
  input  logic [LENW-1:0] len,
  output logic [CW-1:0]   beats_m1
);
  // Fixed kinds: pairs (2,3)->4, (4,5)->8, (6,7)->16 beats.
  always_comb begin
    if (kind == BK_SINGLE)     beats_m1 = '0;
    else if (kind == BK_INCR)  beats_m1 = CW'(len);
    else                       beats_m1 = (CW'(2) << kind[2:1]) - CW'(1);
  end
endmodule

// File: rtl/bseq_addr.sv
module bseq_addr
  import bseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int NB = 4
) (
  input  logic [AW-1:0] cur,
  input  logic [2:0]    kind,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] STEP = AW'(NB);

  logic [AW-1:0] inc;
  logic [AW-1:0] line_mask;

  always_comb begin
    inc       = cur + STEP;
    // Line size in bytes = beats * NB, with beats = 2 << kind[2:1].
    line_mask = (AW'(2 * NB) << kind[2:1]) - AW'(1);
    if (kind_wraps(kind)) nxt = (cur & ~line_mask) | (inc & line_mask);
    else                  nxt = inc;
  end
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NB   = 4,
  parameter int LENW = 4,
  parameter int CW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  input  logic [2:0]    cmd_kind,
  input  logic [LENW-1:0] cmd_len,
  input  logic          cmd_write,
  input  logic          hready,
  output logic          act,
  output logic          first,
  output logic [AW-1:0] addr,
  output logic [2:0]    kind,
  output logic          wr
);
  localparam int LSB = $clog2(NB);

  logic [CW-1:0] rem;
  logic [CW-1:0] beats_m1;
  logic [AW-1:0] nxt;
  logic [AW-1:0] start_al;

  bseq_len #(.LENW(LENW), .CW(CW)) u_len (
    .kind     (cmd_kind),
    .len      (cmd_len),
    .beats_m1 (beats_m1)
  );

  bseq_addr #(.AW(AW), .NB(NB)) u_addr (
    .cur  (addr),
    .kind (kind),
    .nxt  (nxt)
  );

  assign start_al = {cmd_addr[AW-1:LSB], {LSB{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= 1'b0;
      first <= 1'b0;
      rem   <= '0;
      addr  <= '0;
      kind  <= BK_SINGLE;
      wr    <= 1'b0;
    end else if (!act) begin
      if (cmd_valid) begin
        act   <= 1'b1;
        first <= 1'b1;
        addr  <= start_al;
        kind  <= cmd_kind;
        wr    <= cmd_write;
        rem   <= beats_m1;
      end
    end else if (hready) begin
      if (rem == '0) begin
        act <= 1'b0;
      end else begin
        addr  <= nxt;
        first <= 1'b0;
        rem   <= rem - CW'(1);
      end
    end
  end
endmodule

// File: rtl/bseq_dphase.sv
module bseq_dphase #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic          wr,
  input  logic          hready,
  input  logic          wd_valid,
  input  logic [DW-1:0] wd_data,
  input  logic [DW-1:0] hrdata,
  output logic          wd_ready,
  output logic [DW-1:0] hwdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic dp_act;
  logic dp_wr;

  assign wd_ready = act & wr & hready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_act <= 1'b0;
      dp_wr  <= 1'b0;
      hwdata <= '0;
    end else if (hready) begin
      dp_act <= act;
      dp_wr  <= wr;
      if (wd_ready && wd_valid) hwdata <= wd_data;
    end
  end

  assign rd_valid = dp_act & ~dp_wr & hready;
  assign rd_data  = hrdata;
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import bseq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LENW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [2:0]      cmd_kind,
  input  logic [LENW-1:0] cmd_len,
  input  logic            cmd_write,
  input  logic            wd_valid,
  output logic            wd_ready,
  input  logic [DW-1:0]   wd_data,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [1:0]      htrans,
  output logic [AW-1:0]   haddr,
  output logic            hwrite,
  output logic [2:0]      hsize,
  output logic [2:0]      hburst,
  output logic [DW-1:0]   hwdata,
  input  logic            hready,
  input  logic [DW-1:0]   hrdata
);
  localparam int NB   = DW / 8;
  localparam int CW   = (LENW > 4) ? LENW : 4;
  localparam logic [2:0] SIZE = 3'($clog2(NB));

  logic act;
  logic first;
  logic wr;

  bseq_ctrl #(.AW(AW), .NB(NB), .LENW(LENW), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid & cmd_ready),
    .cmd_addr  (cmd_addr),
    .cmd_kind  (cmd_kind),
    .cmd_len   (cmd_len),
    .cmd_write (cmd_write),
    .hready    (hready),
    .act       (act),
    .first     (first),
    .addr      (haddr),
    .kind      (hburst),
    .wr        (wr)
  );

  bseq_dphase #(.DW(DW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .wr       (wr),
    .hready   (hready),
    .wd_valid (wd_valid),
    .wd_data  (wd_data),
    .hrdata   (hrdata),
    .wd_ready (wd_ready),
    .hwdata   (hwdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign cmd_ready = ~act;
  assign htrans    = !act ? TR_IDLE : (first ? TR_NSEQ : TR_SEQ);
  assign hwrite    = wr;
  assign hsize     = SIZE;
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int AW = 32,
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    htrans,
  input logic [AW-1:0] haddr,
  input logic [2:0]    hburst,
  input logic          hwrite,
  input logic [2:0]    hsize,
  input logic          hready,
  input logic          wd_ready,
  input logic          cmd_ready,
  input logic          rd_valid
);
  logic          moving;
  logic          wrapk;
  logic [AW-1:0] line_lo;

  assign moving  = (htrans != 2'b00) && hready;
  assign wrapk   = (hburst != 3'd0) && !hburst[0];
  assign line_lo = ~((AW'(2 * NB) << hburst[2:1]) - AW'(1));

  // R2
  seq_follows_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11) |-> ($past(htrans) != 2'b00));

  // R3
  incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (moving && !wrapk) ##1 (htrans == 2'b11) |-> (haddr == $past(haddr) + AW'(NB)));

  // R4
  wrap_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (moving && wrapk) ##1 (htrans == 2'b11) |-> ((haddr & line_lo) == ($past(haddr) & line_lo)));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((htrans != 2'b00) && !hready) |=> ($stable(htrans) && $stable(haddr) && $stable(hburst)
                                        && $stable(hwrite) && $stable(hsize)));

  // R6
  wd_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> (moving && hwrite));

  // R9
  busy_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'b00) |-> !cmd_ready);

  // R8
  rd_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> hready);

  // R10
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'b00) |-> (haddr[1:0] == 2'b00));
endmodule

bind burst_seq bseq_chk #(.AW(AW), .NB(DW / 8)) u_bseq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .htrans    (htrans),
  .haddr     (haddr),
  .hburst    (hburst),
  .hwrite    (hwrite),
  .hsize     (hsize),
  .hready    (hready),
  .wd_ready  (wd_ready),
  .cmd_ready (cmd_ready),
  .rd_valid  (rd_valid)
);

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [2:0]  cmd_kind = '0;
  logic [3:0]  cmd_len = '0;
  logic        cmd_write = 1'b0;
  logic        wd_valid = 1'b0;
  logic        wd_ready;
  logic [31:0] wd_data = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [1:0]  htrans;
  logic [31:0] haddr;
  logic        hwrite;
  logic [2:0]  hsize;
  logic [2:0]  hburst;
  logic [31:0] hwdata;
  logic        hready = 1'b1;
  logic [31:0] hrdata = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  localparam logic [31:0] BASE = 32'h2000_0400;

  always #5 clk = ~clk;

  burst_seq u_burst_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_kind(cmd_kind), .cmd_len(cmd_len), .cmd_write(cmd_write),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .htrans(htrans), .haddr(haddr),
    .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
    .hready(hready), .hrdata(hrdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] wword(input int tag, input int i);
    return 32'hC0DE_0000 ^ (32'(tag) << 6) ^ 32'(i);
  endfunction

  function automatic logic [31:0] rword(input logic [31:0] a);
    return ~a ^ 32'h0F0F_A5A5;
  endfunction

  function automatic bit ready_at(input int mode, input int c);
    if (mode == 0) return 1'b1;
    if (mode == 1) return (c % 3) != 1;
    return (c % 4) < 2;
  endfunction

  task automatic run_burst(input int kind, input bit wr, input int off, input int mode);
    int nb, len, blk, tag;
    logic [31:0] start, lbase, exp_a;
    int a_i = 0, d_i = 0, wd_i = 0, rd_cnt = 0, guard = 0;
    bit pend = 0;
    int pend_idx = 0;
    logic [31:0] pend_addr = '0;
    bit stall_a = 0, stall_d = 0;
    logic [1:0] p_tr; logic [31:0] p_ad; logic [2:0] p_bu; logic p_wr; logic [31:0] p_wd;

    len = (off * 5) % 16;
    if (kind == 0) nb = 1;
    else if (kind == 1) nb = len + 1;
    else nb = 2 << (kind >> 1);
    blk = nb * 4;
    tag = kind * 64 + off * 2 + int'(wr);
    start = BASE + 32'(off * 4);
    lbase = start - (start % 32'(blk));

    @(negedge clk);
    cyc++;
    hready = 1'b1;
    cmd_valid = 1'b1;
    cmd_addr = start + 32'(off % 4);   // R10: low bits must be ignored
    cmd_kind = 3'(kind);
    cmd_len = 4'(len);
    cmd_write = wr;
    wd_valid = wr;
    wd_data = wword(tag, 0);
    #1;
    chk(cmd_ready == 1'b1, "R9 cmd_ready idle", 32'(cmd_ready), 32'd1);

    while (d_i < nb && guard < 300) begin
      @(negedge clk);
      cyc++;
      guard++;
      cmd_valid = 1'b0;
      hready = ready_at(mode, cyc);
      hrdata = pend ? rword(pend_addr) : 32'h0;
      wd_data = wword(tag, wd_i);
      #1;
      if (stall_a) begin
        chk(htrans == p_tr && haddr == p_ad, "R7 addr hold", haddr, p_ad);
        chk(hburst == p_bu && hwrite == p_wr, "R7 ctrl hold", {29'd0, hburst}, {29'd0, p_bu});
      end
      if (stall_d && wr) chk(hwdata == p_wd, "R7 wdata hold", hwdata, p_wd);
      if (htrans != 2'b00) chk(cmd_ready == 1'b0, "R9 busy", 32'(cmd_ready), 32'd0);

      if (pend && hready) begin
        if (wr) chk(hwdata == wword(tag, pend_idx), "R6 hwdata", hwdata, wword(tag, pend_idx));
        else begin
          chk(rd_valid == 1'b1 && rd_data == rword(pend_addr), "R8 read return", rd_data, rword(pend_addr));
          rd_cnt++;
        end
        d_i++;
      end else begin
        chk(rd_valid == 1'b0, "R8 no return", 32'(rd_valid), 32'd0);
      end

      if (htrans != 2'b00 && hready) begin
        if (a_i >= nb) chk(1'b0, "R3 extra beat", 32'(a_i), 32'(nb));
        if (kind != 0 && kind[0] == 1'b0) exp_a = lbase + ((start - lbase + 32'(4 * a_i)) % 32'(blk));
        else exp_a = start + 32'(4 * a_i);
        chk(htrans == (a_i == 0 ? 2'b10 : 2'b11), "R2 trans type", 32'(htrans), (a_i == 0) ? 32'd2 : 32'd3);
        chk(haddr == exp_a, (kind != 0 && kind[0] == 1'b0) ? "R4 wrap addr" : "R3 incr addr", haddr, exp_a);
        chk(hburst == 3'(kind) && hwrite == wr && hsize == 3'b010, "R5 control",
            {hsize, hwrite, hburst}, {3'b010, wr, 3'(kind)});
        chk(wd_ready == wr, "R6 wd_ready", 32'(wd_ready), 32'(wr));
        pend = 1'b1;
        pend_idx = a_i;
        pend_addr = haddr;
        a_i++;
      end else begin
        chk(wd_ready == 1'b0, "R6 wd_ready quiet", 32'(wd_ready), 32'd0);
        if (hready) pend = 1'b0;
      end
      if (wd_ready && wd_valid) wd_i++;

      stall_a = (htrans != 2'b00) && !hready;
      stall_d = pend && !hready;
      p_tr = htrans; p_ad = haddr; p_bu = hburst; p_wr = hwrite; p_wd = hwdata;
    end

    @(negedge clk);
    cyc++;
    hready = 1'b1;
    wd_valid = 1'b0;
    #1;
    chk(htrans == 2'b00 && cmd_ready == 1'b1, "R9 idle after last", {30'd0, htrans}, 32'd0);
    chk(a_i == nb, "R3 beat count", 32'(a_i), 32'(nb));
    if (!wr) chk(rd_cnt == nb, "R8 read count", 32'(rd_cnt), 32'(nb));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(htrans == 2'b00, "R1 reset trans", {30'd0, htrans}, 32'd0);
    chk(cmd_ready == 1'b1, "R1 reset cmd_ready", 32'(cmd_ready), 32'd1);
    chk(rd_valid == 1'b0 && wd_ready == 1'b0, "R1 reset strobes", {30'd0, rd_valid, wd_ready}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int mode = 0; mode < 3; mode++)
      for (int kind = 0; kind < 8; kind++)
        for (int wr = 0; wr < 2; wr++)
          for (int off = 0; off < 16; off++)
            run_burst(kind, wr[0], off, mode);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule